// File: doc/BRIEF.md
# Line Sensor Drive Timing Generator

This block produces every digital drive waveform that a self-scanning photodiode-array line sensor needs, counted out from a fast system clock. Each line it emits a start pulse, two non-overlapping clock phases, an integrator reset pulse before each pixel is addressed and a one-cycle pixel-valid strobe on every phase-two rise that carries pixel video. All timing values are given in system-clock cycles and are sampled only when a line begins. Values below the sensor's minimums (200 ns for high widths, 50 ns for the reset delay) are raised to those minimums at that point.

A line is built from slots, and each slot is phase one high, a gap, phase two high, then a gap. Slot 0 carries the start pulse. Slots 1..N address the N pixels. Slot N+1 is where the sensor answers with its active-low end-of-scan. After the slots an idle tail pads the line out to the programmed line period, and that period sets the integration time. The end-of-scan input is synchronized and checked against the slot N+1 phase-two window. Every line ends with a completion pulse, plus an error pulse if the answer was missing. When the enable drops, the line in progress is completed and all outputs then stay low.

Top module: `lsen_timing_gen`

## Requirements
- R1: `ph1_o` and `ph2_o` are never high in the same cycle. With a gap of 0 they are complementary: one phase rises in the cycle the other falls.
- R2: Every phase high pulse lasts exactly H cycles, where H = max(`cfg_phase_hi`, ceil(200/CLK_NS)). At the default 10 ns clock that minimum is 20.
- R3: Between the fall of one phase and the rise of the other there are exactly G = `cfg_gap` low cycles inside the slots.
- R4: `st_o` rises together with the slot-0 phase-two rise and stays high for H+1 cycles. It therefore overlaps phase two by H cycles and contains exactly one phase-two fall.
- R5: The interval between successive `st_o` rises equals max(`cfg_line_period`, (N+2)·(2H+2G)+4), where N = max(`cfg_pixels`, 1).
- R6: `pix_valid_o` pulses for one cycle only in a cycle where `ph2_o` rises, on slots 1..N only, giving N pulses per line.
- R7: `irst_o` rises exactly D cycles after a phase-two fall, where D = `cfg_rst_dly` clamped to [ceil(50/CLK_NS), H+G-1]. It stays high through the end of the next phase-one pulse. It never overlaps `ph2_o` and follows only the phase-two falls of slots 0..N.
- R8: `eos_n` passes through a two-flop synchronizer. If it is seen low during the slot N+1 phase-two window, the line ends with a one-cycle `line_done_o` and no `eos_err_o`.
- R9: If `eos_n` stays high through that window, `eos_err_o` pulses in the same cycle as `line_done_o`.
- R10: Configuration inputs are sampled only when a line starts. A change made during a line leaves that line's timing untouched and takes effect from the next line.
- R11: After reset all outputs are low. When `en` is low at a line boundary no new line starts, the current line still finishes with its `line_done_o`, and all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable, sampled at line boundaries |
| cfg_pixels | input | PIX_W | Pixels per line (N) |
| cfg_phase_hi | input | CNT_W | Phase high width in cycles (H) |
| cfg_gap | input | CNT_W | Dead gap between phases in cycles (G) |
| cfg_rst_dly | input | CNT_W | Integrator reset delay after phase-two fall (D) |
| cfg_line_period | input | LINE_W | Line period in cycles |
| eos_n | input | 1 | Sensor end-of-scan, active low, asynchronous |
| st_o | output | 1 | Start pulse |
| ph1_o | output | 1 | Clock phase one |
| ph2_o | output | 1 | Clock phase two |
| irst_o | output | 1 | Integrator reset pulse |
| pix_valid_o | output | 1 | Pixel video strobe |
| line_done_o | output | 1 | One-cycle line completion pulse |
| eos_err_o | output | 1 | One-cycle missing end-of-scan pulse |

## Verification
The assertions assume a synchronous reset held for at least one clock edge. They assume `eos_n` is a level that, when present, is held low for the whole phase-two pulse it answers, so the synchronized copy overlaps the delayed window. They do not assume the configuration is stable, because it is latched at line start. The stimulus respects this with a sensor model that drives `eos_n` low only while it sees the slot N+1 phase-two pulse. Configuration and enable are changed away from clock edges, and the end-of-scan model is switched off only just after a line completes, so no partial answer reaches the checker.

// File: rtl/lsen_pkg.sv
package lsen_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ONE  = 3'd1,
    PH_GAP1 = 3'd2,
    PH_TWO  = 3'd3,
    PH_GAP2 = 3'd4,
    PH_TAIL = 3'd5
  } phase_e;

  localparam int TAIL_MIN = 4;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/lsen_cfg_latch.sv
module lsen_cfg_latch #(
  parameter int CLK_NS = 10,
  parameter int PIX_W  = 10,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PIX_W-1:0]  raw_pix,
  input  logic [CNT_W-1:0]  raw_hi,
  input  logic [CNT_W-1:0]  raw_gap,
  input  logic [CNT_W-1:0]  raw_dly,
  input  logic [LINE_W-1:0] raw_period,
  output logic [PIX_W-1:0]  lat_pix,
  output logic [CNT_W-1:0]  lat_hi,
  output logic [CNT_W-1:0]  lat_gap,
  output logic [CNT_W-1:0]  lat_dly,
  output logic [LINE_W-1:0] lat_period
);
  import lsen_pkg::*;

  localparam int MIN_HI  = ceil_div(200, CLK_NS);
  localparam int MIN_DLY = ceil_div(50, CLK_NS);

  logic [PIX_W-1:0]  pix_c;
  logic [CNT_W-1:0]  hi_c;
  logic [CNT_W-1:0]  dly_c;
  logic [CNT_W:0]    dly_max;
  logic [LINE_W-1:0] slot_len;
  logic [LINE_W-1:0] per_min;
  logic [LINE_W-1:0] per_c;

  always_comb begin
    pix_c   = (raw_pix == '0) ? PIX_W'(1) : raw_pix;
    hi_c    = (raw_hi < CNT_W'(MIN_HI)) ? CNT_W'(MIN_HI) : raw_hi;
    dly_max = {1'b0, hi_c} + {1'b0, raw_gap} - (CNT_W+1)'(1);
    if (raw_dly < CNT_W'(MIN_DLY))
      dly_c = CNT_W'(MIN_DLY);
    else if ({1'b0, raw_dly} > dly_max)
      dly_c = dly_max[CNT_W-1:0];
    else
      dly_c = raw_dly;
    slot_len = LINE_W'(2) * (LINE_W'(hi_c) + LINE_W'(raw_gap));
    per_min  = (LINE_W'(pix_c) + LINE_W'(2)) * slot_len + LINE_W'(TAIL_MIN);
    per_c    = (raw_period < per_min) ? per_min : raw_period;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_pix    <= '0;
      lat_hi     <= '0;
      lat_gap    <= '0;
      lat_dly    <= '0;
      lat_period <= '0;
    end else if (load) begin
      lat_pix    <= pix_c;
      lat_hi     <= hi_c;
      lat_gap    <= raw_gap;
      lat_dly    <= dly_c;
      lat_period <= per_c;
    end
  end
endmodule

// File: rtl/lsen_phase_seq.sv
module lsen_phase_seq #(
  parameter int PIX_W  = 10,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PIX_W-1:0]  pix,
  input  logic [CNT_W-1:0]  hi,
  input  logic [CNT_W-1:0]  gap,
  input  logic [CNT_W-1:0]  dly,
  input  logic [LINE_W-1:0] period,
  output logic              load_o,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic              st_o,
  output logic              irst_o,
  output logic              pix_valid_o,
  output logic              eos_win_o
);
  import lsen_pkg::*;

  localparam int SLOT_W = PIX_W + 1;
  localparam int ELP_W  = CNT_W + 1;

  phase_e             ph, ph_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [SLOT_W-1:0]  slot, slot_n;
  logic [LINE_W-1:0]  line_cnt, line_n;
  logic [ELP_W-1:0]   elp, elp_n;
  logic               armed, armed_n;
  logic               last_slot;
  logic               ph2_fall;
  logic [SLOT_W-1:0]  eos_slot;
  logic [ELP_W-1:0]   rst_end;

  assign eos_slot  = {1'b0, pix} + SLOT_W'(1);
  assign last_slot = (slot == eos_slot);
  assign rst_end   = {1'b0, hi} + {1'b0, gap};

  // phase and slot advance
  always_comb begin
    ph_n   = ph;
    cnt_n  = cnt + CNT_W'(1);
    slot_n = slot;
    line_n = line_cnt + LINE_W'(1);
    load_o = 1'b0;
    case (ph)
      PH_IDLE: begin
        cnt_n  = '0;
        line_n = '0;
        if (en) begin
          load_o = 1'b1;
          ph_n   = PH_ONE;
          slot_n = '0;
        end
      end
      PH_ONE: if (cnt == hi - CNT_W'(1)) begin
        cnt_n = '0;
        ph_n  = (gap == '0) ? PH_TWO : PH_GAP1;
      end
      PH_GAP1: if (cnt == gap - CNT_W'(1)) begin
        cnt_n = '0;
        ph_n  = PH_TWO;
      end
      PH_TWO: if (cnt == hi - CNT_W'(1)) begin
        cnt_n = '0;
        if (gap != '0)
          ph_n = PH_GAP2;
        else if (last_slot)
          ph_n = PH_TAIL;
        else begin
          ph_n   = PH_ONE;
          slot_n = slot + SLOT_W'(1);
        end
      end
      PH_GAP2: if (cnt == gap - CNT_W'(1)) begin
        cnt_n = '0;
        if (last_slot)
          ph_n = PH_TAIL;
        else begin
          ph_n   = PH_ONE;
          slot_n = slot + SLOT_W'(1);
        end
      end
      PH_TAIL: if (line_cnt == period - LINE_W'(1)) begin
        cnt_n  = '0;
        line_n = '0;
        if (en) begin
          load_o = 1'b1;
          ph_n   = PH_ONE;
          slot_n = '0;
        end else begin
          ph_n = PH_IDLE;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  // elapsed cycles since the last phase-two fall, for the integrator reset
  always_comb begin
    ph2_fall = (ph == PH_TWO) && (ph_n != PH_TWO);
    armed_n  = armed;
    if (load_o)
      armed_n = 1'b0;
    if (ph2_fall) begin
      elp_n   = '0;
      armed_n = (slot <= {1'b0, pix});
    end else if (elp == '1) begin
      elp_n = elp;
    end else begin
      elp_n = elp + ELP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_IDLE;
      cnt         <= '0;
      slot        <= '0;
      line_cnt    <= '0;
      elp         <= '1;
      armed       <= 1'b0;
      ph1_o       <= 1'b0;
      ph2_o       <= 1'b0;
      st_o        <= 1'b0;
      irst_o      <= 1'b0;
      pix_valid_o <= 1'b0;
      eos_win_o   <= 1'b0;
    end else begin
      ph          <= ph_n;
      cnt         <= cnt_n;
      slot        <= slot_n;
      line_cnt    <= line_n;
      elp         <= elp_n;
      armed       <= armed_n;
      ph1_o       <= (ph_n == PH_ONE);
      ph2_o       <= (ph_n == PH_TWO);
      st_o        <= ((ph_n == PH_TWO) && (slot_n == '0)) ||
                     ((ph == PH_TWO) && (slot == '0) && (ph_n != PH_TWO));
      irst_o      <= armed_n && (elp_n >= {1'b0, dly}) && (elp_n < rst_end);
      pix_valid_o <= (ph_n == PH_TWO) && (ph != PH_TWO) &&
                     (slot_n != '0) && (slot_n <= {1'b0, pix});
      eos_win_o   <= (ph_n == PH_TWO) && (slot_n == eos_slot);
    end
  end
endmodule

// File: rtl/lsen_eos_mon.sv
module lsen_eos_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic eos_n,
  input  logic win,
  output logic line_done_o,
  output logic eos_err_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES:0]   win_q;
  logic                   seen;
  logic                   eos_low;
  logic                   win_al;
  logic                   win_end;

  assign eos_low = ~sync_q[SYNC_STAGES-1];
  assign win_al  = win_q[SYNC_STAGES-1];
  assign win_end = win_q[SYNC_STAGES] & ~win_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], eos_n};
      win_q  <= {win_q[SYNC_STAGES-1:0], win};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen        <= 1'b0;
      line_done_o <= 1'b0;
      eos_err_o   <= 1'b0;
    end else if (win_end) begin
      seen        <= 1'b0;
      line_done_o <= 1'b1;
      eos_err_o   <= ~seen;
    end else begin
      seen        <= seen | (win_al & eos_low);
      line_done_o <= 1'b0;
      eos_err_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/lsen_timing_gen.sv
module lsen_timing_gen #(
  parameter int CLK_NS = 10,
  parameter int PIX_W  = 10,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PIX_W-1:0]  cfg_pixels,
  input  logic [CNT_W-1:0]  cfg_phase_hi,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [CNT_W-1:0]  cfg_rst_dly,
  input  logic [LINE_W-1:0] cfg_line_period,
  input  logic              eos_n,
  output logic              st_o,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic              irst_o,
  output logic              pix_valid_o,
  output logic              line_done_o,
  output logic              eos_err_o
);
  logic              load;
  logic              eos_win;
  logic [PIX_W-1:0]  lat_pix;
  logic [CNT_W-1:0]  lat_hi;
  logic [CNT_W-1:0]  lat_gap;
  logic [CNT_W-1:0]  lat_dly;
  logic [LINE_W-1:0] lat_period;

  lsen_cfg_latch #(
    .CLK_NS(CLK_NS), .PIX_W(PIX_W), .CNT_W(CNT_W), .LINE_W(LINE_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .raw_pix(cfg_pixels), .raw_hi(cfg_phase_hi), .raw_gap(cfg_gap),
    .raw_dly(cfg_rst_dly), .raw_period(cfg_line_period),
    .lat_pix(lat_pix), .lat_hi(lat_hi), .lat_gap(lat_gap),
    .lat_dly(lat_dly), .lat_period(lat_period)
  );

  lsen_phase_seq #(
    .PIX_W(PIX_W), .CNT_W(CNT_W), .LINE_W(LINE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .en(en),
    .pix(lat_pix), .hi(lat_hi), .gap(lat_gap), .dly(lat_dly), .period(lat_period),
    .load_o(load), .ph1_o(ph1_o), .ph2_o(ph2_o), .st_o(st_o),
    .irst_o(irst_o), .pix_valid_o(pix_valid_o), .eos_win_o(eos_win)
  );

  lsen_eos_mon #(
    .SYNC_STAGES(2)
  ) u_eos (
    .clk(clk), .rst(rst), .eos_n(eos_n), .win(eos_win),
    .line_done_o(line_done_o), .eos_err_o(eos_err_o)
  );
endmodule

// File: rtl/lsen_timing_chk.sv
module lsen_timing_chk #(
  parameter int CLK_NS = 10
) (
  input logic clk,
  input logic rst,
  input logic st_o,
  input logic ph1_o,
  input logic ph2_o,
  input logic irst_o,
  input logic pix_valid_o,
  input logic line_done_o,
  input logic eos_err_o
);
  localparam int MIN_HI = (200 + CLK_NS - 1) / CLK_NS;

  logic [15:0] run1, run2;
  logic [1:0]  falls_in_st;
  logic        ph2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run1        <= '0;
      run2        <= '0;
      falls_in_st <= '0;
      ph2_q       <= 1'b0;
    end else begin
      run1  <= ph1_o ? run1 + 16'd1 : 16'd0;
      run2  <= ph2_o ? run2 + 16'd1 : 16'd0;
      ph2_q <= ph2_o;
      if (!st_o)
        falls_in_st <= '0;
      else if (ph2_q && !ph2_o && falls_in_st != 2'd3)
        falls_in_st <= falls_in_st + 2'd1;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(ph1_o && ph2_o));

  p_ph1_width_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ph1_o) |-> (run1 >= 16'(MIN_HI)));

  p_ph2_width_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ph2_o) |-> (run2 >= 16'(MIN_HI)));

  p_st_on_ph2_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(st_o) |-> ph2_o);

  p_st_one_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (st_o && $fell(ph2_o)) |-> (falls_in_st == 2'd0));

  p_pix_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> $rose(ph2_o));

  p_irst_apart_r7: assert property (@(posedge clk) disable iff (rst)
    irst_o |-> !ph2_o);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    eos_err_o |-> line_done_o);
endmodule

bind lsen_timing_gen lsen_timing_chk #(.CLK_NS(CLK_NS)) u_chk (
  .clk(clk), .rst(rst), .st_o(st_o), .ph1_o(ph1_o), .ph2_o(ph2_o),
  .irst_o(irst_o), .pix_valid_o(pix_valid_o),
  .line_done_o(line_done_o), .eos_err_o(eos_err_o)
);

// File: tb/lsen_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lsen_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 10;
  localparam int CNT_W  = 12;
  localparam int LINE_W = 24;

  logic clk = 0;
  logic rst = 1;
  logic en = 0;
  logic [PIX_W-1:0]  cfg_pixels = '0;
  logic [CNT_W-1:0]  cfg_phase_hi = '0;
  logic [CNT_W-1:0]  cfg_gap = '0;
  logic [CNT_W-1:0]  cfg_rst_dly = '0;
  logic [LINE_W-1:0] cfg_line_period = '0;
  logic eos_n = 1;
  logic st_o, ph1_o, ph2_o, irst_o, pix_valid_o, line_done_o, eos_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsen_timing_gen #(.CLK_NS(CLK_PERIOD), .PIX_W(PIX_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rst(rst), .en(en),
    .cfg_pixels(cfg_pixels), .cfg_phase_hi(cfg_phase_hi), .cfg_gap(cfg_gap),
    .cfg_rst_dly(cfg_rst_dly), .cfg_line_period(cfg_line_period), .eos_n(eos_n),
    .st_o(st_o), .ph1_o(ph1_o), .ph2_o(ph2_o), .irst_o(irst_o),
    .pix_valid_o(pix_valid_o), .line_done_o(line_done_o), .eos_err_o(eos_err_o)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  // monitor state
  bit p1_q, p2_q, st_q, irst_q, have_fall, have_rise;
  int p1_run, p2_run, lo_run, st_run, st_nf, st_ov, ph2cnt, pix_cnt;
  int t_fall, t_rise, st_rises, act_cnt;
  // statistics
  int overlap_cnt, hi_min, hi_max, gap_min, st_w, st_falls, st_ovl;
  int per_last, last_pix, pix_bad, dly_min, dly_max, irst_bad, done_cnt, err_cnt;
  bit eos_on = 1;
  int model_n = 0;

  task automatic reset_stats();
    overlap_cnt = 0; hi_min = 1 << 30; hi_max = 0; gap_min = 1 << 30;
    st_w = -1; st_falls = -1; st_ovl = -1; per_last = -1; have_rise = 0;
    last_pix = -1; pix_bad = 0; dly_min = 1 << 30; dly_max = -1; irst_bad = 0;
    done_cnt = 0; err_cnt = 0;
  endtask

  task automatic note_hi(input int w);
    if (w < hi_min) hi_min = w;
    if (w > hi_max) hi_max = w;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (ph1_o || ph2_o || st_o || irst_o || pix_valid_o || line_done_o || eos_err_o)
      act_cnt = act_cnt + 1;
    if (!rst) begin
      if (ph1_o && ph2_o) overlap_cnt++;
      if (p1_q && !ph1_o) note_hi(p1_run);
      if (p2_q && !ph2_o) begin
        note_hi(p2_run); t_fall = cyc; have_fall = 1;
        if (st_o) st_nf++;
      end
      if (((ph1_o && !p1_q) || (ph2_o && !p2_q)) && have_fall && lo_run < gap_min)
        gap_min = lo_run;
      lo_run = (ph1_o || ph2_o) ? 0 : lo_run + 1;
      p1_run = ph1_o ? p1_run + 1 : 0;
      p2_run = ph2_o ? p2_run + 1 : 0;
      if (st_o && !st_q) begin
        if (have_rise) per_last = cyc - t_rise;
        have_rise = 1; t_rise = cyc; last_pix = pix_cnt; pix_cnt = 0;
        st_rises++; st_run = 0; st_nf = 0; st_ov = 0; ph2cnt = 0;
      end
      if (st_o) begin st_run++; if (ph2_o) st_ov++; end
      if (!st_o && st_q) begin st_w = st_run; st_falls = st_nf; st_ovl = st_ov; end
      if (ph2_o && !p2_q) ph2cnt++;
      if (pix_valid_o) begin
        pix_cnt++;
        if (!(ph2_o && !p2_q)) pix_bad++;
      end
      if (irst_o && !irst_q) begin
        if (cyc - t_fall < dly_min) dly_min = cyc - t_fall;
        if (cyc - t_fall > dly_max) dly_max = cyc - t_fall;
      end
      if (irst_o && ph2_o) irst_bad++;
      if (line_done_o) done_cnt++;
      if (eos_err_o) err_cnt++;
      // sensor model: answer during the phase-two pulse after the last pixel
      eos_n = !(eos_on && ph2_o && ph2cnt == model_n + 2);
      p1_q = ph1_o; p2_q = ph2_o; st_q = st_o; irst_q = irst_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_st(input int k);
    int target = st_rises + k;
    while (st_rises < target) begin @(negedge clk); #1; end
  endtask

  task automatic wait_done(input int k);
    int target = done_cnt + k;
    while (done_cnt < target) begin @(negedge clk); #1; end
  endtask

  task automatic set_cfg(input int n, input int h, input int g, input int d, input int p);
    cfg_pixels = PIX_W'(n); cfg_phase_hi = CNT_W'(h); cfg_gap = CNT_W'(g);
    cfg_rst_dly = CNT_W'(d); cfg_line_period = LINE_W'(p); model_n = n;
  endtask

  task automatic t_reset();
    act_cnt = 0;
    repeat (5) @(negedge clk);
    chk("R11 outputs low in reset", act_cnt, 0);
    #1 rst = 0;
    act_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R11 outputs low while disabled", act_cnt, 0);
  endtask

  task automatic t_normal();
    set_cfg(4, 25, 3, 8, 600);
    reset_stats();
    en = 1;
    wait_st(3);
    wait_done(1);
    chk("R1 phase overlap cycles", overlap_cnt, 0);
    chk("R2 phase high min", hi_min, 25);
    chk("R2 phase high max", hi_max, 25);
    chk("R3 gap cycles", gap_min, 3);
    chk("R4 start width", st_w, 26);
    chk("R4 phi2 falls in start", st_falls, 1);
    chk("R4 start/phi2 overlap", st_ovl, 25);
    chk("R5 line period", per_last, 600);
    chk("R6 pixels per line", last_pix, 4);
    chk("R6 strobe off phi2 rise", pix_bad, 0);
    chk("R7 reset delay min", dly_min, 8);
    chk("R7 reset delay max", dly_max, 8);
    chk("R7 reset overlaps phi2", irst_bad, 0);
    chk("R8 no eos error", err_cnt, 0);
  endtask

  task automatic t_clamp();
    set_cfg(3, 5, 0, 1, 10);
    wait_st(1);
    reset_stats();
    wait_st(2);
    wait_done(1);
    chk("R1 complementary overlap", overlap_cnt, 0);
    chk("R1 complementary gap", gap_min, 0);
    chk("R2 clamped high min", hi_min, 20);
    chk("R2 clamped high max", hi_max, 20);
    chk("R4 clamped start width", st_w, 21);
    chk("R5 clamped line period", per_last, 204);
    chk("R6 pixels per line", last_pix, 3);
    chk("R7 clamped delay", dly_min, 5);
    chk("R7 clamped delay max", dly_max, 5);
  endtask

  task automatic t_cfg_midline();
    wait_st(1);
    reset_stats();
    cfg_phase_hi = CNT_W'(40);
    wait_done(1);
    chk("R10 current line keeps width min", hi_min, 20);
    chk("R10 current line keeps width max", hi_max, 20);
    reset_stats();
    wait_st(2);
    chk("R10 next line width", hi_min, 40);
    chk("R10 next line period", per_last, 404);
  endtask

  task automatic t_eos();
    wait_done(1);
    eos_on = 0;
    reset_stats();
    wait_done(2);
    chk("R9 error pulses", err_cnt, 2);
    chk("R9 done pulses", done_cnt, 2);
    eos_on = 1;
    reset_stats();
    wait_done(2);
    chk("R8 answered lines no error", err_cnt, 0);
  endtask

  task automatic t_disable();
    int r0, d0;
    wait_st(1);
    en = 0;
    r0 = st_rises;
    d0 = done_cnt;
    repeat (3 * 404) @(negedge clk);
    #1;
    chk("R11 no new line after disable", st_rises, r0);
    chk("R11 line finished", done_cnt, d0 + 1);
    act_cnt = 0;
    repeat (50) @(negedge clk);
    chk("R11 parked low", act_cnt, 0);
  endtask

  initial begin
    reset_stats();
    t_reset();
    t_normal();
    t_clamp();
    t_cfg_midline();
    t_eos();
    t_disable();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule